// File: doc/BRIEF.md
# I2C Indexed Block-Transfer Register Target

This block is an I2C target that gives a host access to a bank of 8-bit configuration registers. Every transfer is indexed. A write carries a starting index, then a byte count, then that many data bytes. The data bytes land in consecutive registers. A read first sets the index with a short write phase. The host then issues a repeated START and the read address. The target answers with a count byte, followed by consecutive register contents. The count byte is taken from a dedicated register, so software decides how long a read is expected to run.

Both bus lines are sampled through synchronisers into a system clock that runs at least eight times faster than SCL. START and STOP are recognised from SDA edges while SCL is high. The open-drain SDA line is modelled as an input plus an output-enable that pulls the line low. The rest of the chip sees the whole register bank as one flat parallel vector. Register k occupies bits [8k+7:8k].

Top module: `i2c_blk_regs`

## Requirements
- R1: The target acknowledges (holds SDA low through the ACK slot) an address byte whose upper seven bits equal 0x69. An LSB of 0 (0xD2) selects write and an LSB of 1 (0xD3) selects read.
- R2: Any other address byte is not acknowledged. The target then leaves SDA released and ignores all bytes until the next START. No register changes.
- R3: In a write, the byte after the address is the starting index N and the next byte is the count X. Each of the following X data bytes is stored into register N, N+1, and so on. Index, count and every stored data byte are acknowledged.
- R4: A data byte received after X bytes of the current write have been stored is not acknowledged and is not stored.
- R5: The register index wraps modulo 32 (32 registers), for both writes and reads. Only the low five bits of the index byte are used.
- R6: After the index phase, a repeated START and 0xD3 make the target send register 8 first (the count byte). It then sends register N, N+1, and so on, MSB first.
- R7: The target sends another byte while the host ACKs the previous one. A host NACK ends the read, and SDA stays released until the next START.
- R8: A START or STOP that arrives before a data byte has been acknowledged aborts the transfer. That byte is not stored, and bytes already acknowledged stay stored.
- R9: After reset, SDA is released. Register 8 holds 0x04 and every other register holds 0x00.
- R10: The SDA output-enable only changes while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| regs_o | output | 256 | Flat register bank, register k at bits [8k+7:8k] |

## Verification
Writes are tried with several patterns:
- a plain in-range burst;
- a burst that crosses index 31, which separates wrap-around from overflow;
- a burst with one byte beyond its count, which separates acknowledge-and-store from refuse-and-drop.

A foreign address followed by bytes that would otherwise form a valid write shows whether the target truly goes deaf. Reads are tried from a mid-bank index and across the wrap point, after software has changed the count register, so the leading count byte is told apart from register data. Aborts by STOP and by repeated START inside a data byte separate committed bytes from partial ones.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK} st_e;
  typedef enum logic [1:0] {B_ADDR, B_INDEX, B_COUNT, B_DATA} role_e;
endpackage

// File: rtl/i2c_blk_sync.sv
module i2c_blk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_blk_regfile.sv
module i2c_blk_regfile #(
  parameter int         NUM_REGS = 32,
  parameter int         AW       = 5,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] CNT_RST  = 8'h04
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == CNT_IDX) ? CNT_RST : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[g*8 +: 8] <= RST_V;
      else if (we_i && waddr_i == AW'(g))        regs_o[g*8 +: 8] <= wdata_i;
    end
  end

  // registers move only on a commit strobe
  assert_regs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/i2c_blk_regs.sv
module i2c_blk_regs
  import i2c_blk_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         NUM_REGS    = 32,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'h04,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW = $clog2(NUM_REGS);

  logic scl_s, sda_s, rise, fall, start_det, stop_det;
  logic we_w;
  logic [7:0] cur_byte, cnt_byte;

  st_e        st_q;
  role_e      role_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, rem_q;
  logic [AW-1:0] idx_q;
  logic oe_q, commit_q, rd_q, hack_q;

  i2c_blk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign we_w     = (st_q == S_RX_ACK) && fall && commit_q && !start_det && !stop_det;
  assign cur_byte = regs_o[{idx_q, 3'b000} +: 8];
  assign cnt_byte = regs_o[CNT_IDX*8 +: 8];

  i2c_blk_regfile #(.NUM_REGS(NUM_REGS), .AW(AW), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_rf (
    .clk_i, .rst_ni, .we_i(we_w), .waddr_i(idx_q), .wdata_i(sh_q), .regs_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; role_q <= B_ADDR; bit_q <= '0; sh_q <= '0;
      idx_q <= '0; rem_q <= '0; oe_q <= 1'b0;
      commit_q <= 1'b0; rd_q <= 1'b0; hack_q <= 1'b0;
    end else if (start_det) begin
      st_q <= S_RX; role_q <= B_ADDR; bit_q <= '0;
      oe_q <= 1'b0; commit_q <= 1'b0; rd_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= S_IDLE; oe_q <= 1'b0; commit_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (rise && bit_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 4'd1;
          end else if (fall && bit_q == 4'd8) begin
            bit_q <= '0; st_q <= S_RX_ACK; commit_q <= 1'b0; rd_q <= 1'b0;
            unique case (role_q)
              B_ADDR: begin
                if (sh_q[7:1] == ADDR7) begin
                  oe_q <= 1'b1; rd_q <= sh_q[0]; role_q <= B_INDEX;
                end else begin
                  st_q <= S_IDLE;
                end
              end
              B_INDEX: begin oe_q <= 1'b1; idx_q <= sh_q[AW-1:0]; role_q <= B_COUNT; end
              B_COUNT: begin oe_q <= 1'b1; rem_q <= sh_q; role_q <= B_DATA; end
              B_DATA: begin
                oe_q     <= (rem_q != 8'd0);
                commit_q <= (rem_q != 8'd0);
              end
              default: ;
            endcase
          end
        end
        S_RX_ACK: if (fall) begin
          commit_q <= 1'b0;
          bit_q    <= '0;
          if (rd_q) begin
            st_q <= S_TX; sh_q <= cnt_byte; oe_q <= ~cnt_byte[7];
          end else begin
            st_q <= S_RX; oe_q <= 1'b0;
          end
          if (commit_q) begin
            idx_q <= idx_q + AW'(1);
            rem_q <= rem_q - 8'd1;
          end
        end
        S_TX: if (fall) begin
          if (bit_q == 4'd7) begin
            st_q <= S_TX_ACK; oe_q <= 1'b0;
          end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            oe_q  <= ~sh_q[6];
            bit_q <= bit_q + 4'd1;
          end
        end
        S_TX_ACK: begin
          if (rise) hack_q <= ~sda_s;
          else if (fall) begin
            if (hack_q) begin
              st_q <= S_TX; sh_q <= cur_byte; oe_q <= ~cur_byte[7];
              idx_q <= idx_q + AW'(1); bit_q <= '0;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s);
  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE) |-> !oe_q);
  assert_start_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st_q == S_RX && !oe_q));
  assert_ack_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RX_ACK && scl_s && $past(scl_s)) |-> $stable(oe_q));
  assert_no_write_past_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_w |-> (rem_q != 8'd0));
endmodule

// File: tb/i2c_blk_regs_tb.sv
module i2c_blk_regs_tb;
  localparam int N = 32;
  localparam time Q = 50ns;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] regs;
  wire  sda_line = sda_h & ~sda_oe;

  int nchk = 0, nerr = 0;
  logic [7:0] mem [N];
  logic [7:0] exp_v [$];
  string      exp_r [$];
  logic [7:0] last_rx;
  event       rx_ev;

  always #2.5ns clk = ~clk;

  i2c_blk_regs u_dut (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
                      .sda_oe_o(sda_oe), .regs_o(regs));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    int bad = -1;
    nchk++;
    for (int i = 0; i < N; i++) if (regs[i*8 +: 8] !== mem[i] && bad < 0) bad = i;
    if (bad >= 0) begin
      nerr++;
      $display("FAIL %s reg %0d actual %0h expected %0h", req, bad, regs[bad*8 +: 8], mem[bad]);
    end
  endtask

  // monitor: compares each byte read off the bus with the scoreboard head
  initial forever begin
    @(rx_ev);
    nchk++;
    if (exp_v.size() == 0) begin
      nerr++;
      $display("FAIL R6 unexpected byte actual %0h expected none", last_rx);
    end else begin
      automatic logic [7:0] e = exp_v.pop_front();
      automatic string r = exp_r.pop_front();
      if (last_rx !== e) begin
        nerr++;
        $display("FAIL %s read byte actual %0h expected %0h", r, last_rx, e);
      end
    end
  end

  task automatic bus_start();
    #Q sda_h = 1'b1; #Q scl = 1'b1; #Q sda_h = 1'b0; #Q scl = 1'b0;
  endtask
  task automatic bus_stop();
    #Q sda_h = 1'b0; #Q scl = 1'b1; #Q sda_h = 1'b1; #Q;
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      #Q sda_h = b[i]; #Q scl = 1'b1; #(2*Q) scl = 1'b0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    #Q sda_h = 1'b1; #Q scl = 1'b1; #Q ack = ~sda_line; #Q scl = 1'b0;
  endtask
  task automatic recv_byte(input logic ack);
    logic [7:0] b;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(2*Q) scl = 1'b1; #Q b[i] = sda_line; #Q scl = 1'b0;
    end
    #Q sda_h = ~ack; #Q scl = 1'b1; #(2*Q) scl = 1'b0; sda_h = 1'b1;
    last_rx = b; ->rx_ev; #1ns;
  endtask

  task automatic wr_head(input logic [7:0] idx, input logic [7:0] cnt, string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk({req, " addr ack R1"}, a, 1);
    send_byte(idx, a);   chk({req, " index ack R3"}, a, 1);
    send_byte(cnt, a);   chk({req, " count ack R3"}, a, 1);
  endtask

  task automatic rd_seq(input int idx, input int ndata, string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(idx[7:0], a);
    bus_start();
    send_byte(8'hD3, a); chk({req, " read addr ack R1"}, a, 1);
    exp_v.push_back(mem[8]); exp_r.push_back({req, " count byte R6"});
    for (int i = 0; i < ndata; i++) begin
      exp_v.push_back(mem[(idx + i) % N]); exp_r.push_back({req, " data R6"});
    end
    for (int i = 0; i <= ndata; i++) recv_byte(i != ndata);
    #(2*Q) chk({req, " released after NACK R7"}, sda_oe, 0);
    bus_stop();
    #(2*Q) chk({req, " queue drained R7"}, exp_v.size(), 0);
  endtask

  initial begin
    #(150_000 * 5ns);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic a;
    for (int i = 0; i < N; i++) mem[i] = (i == 8) ? 8'h04 : 8'h00;
    #(20*5ns) rst_n = 1'b1;
    #(10*5ns);
    chk("R9 sda released", sda_oe, 0);
    chk_regs("R9 reset values");

    // R3 plain burst
    wr_head(8'd3, 8'd4, "R3");
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hA1 + i[7:0], a); chk("R3 data ack", a, 1); mem[3+i] = 8'hA1 + i[7:0];
    end
    bus_stop(); #(2*Q) chk_regs("R3 burst stored");

    // R5 wrap on write; index byte upper bits ignored
    wr_head(8'hFE, 8'd3, "R5");
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hB0 + i[7:0], a); chk("R5 data ack", a, 1); mem[(30+i)%N] = 8'hB0 + i[7:0];
    end
    bus_stop(); #(2*Q) chk_regs("R5 write wrap");

    // R4 one byte beyond count
    wr_head(8'd12, 8'd2, "R4");
    send_byte(8'h11, a); send_byte(8'h22, a); mem[12] = 8'h11; mem[13] = 8'h22;
    send_byte(8'h33, a); chk("R4 extra byte nack", a, 0);
    bus_stop(); #(2*Q) chk_regs("R4 extra byte dropped");

    // R2 foreign address, then a would-be write
    bus_start();
    send_byte(8'hA4, a); chk("R2 foreign addr nack", a, 0);
    send_byte(8'd5, a);  chk("R2 ignored byte nack", a, 0);
    send_byte(8'd1, a);  send_byte(8'hEE, a); chk("R2 ignored data nack", a, 0);
    bus_stop(); #(2*Q) chk_regs("R2 no change");

    // R6/R7 set count register then read mid-bank
    wr_head(8'd8, 8'd1, "R6 cnt");
    send_byte(8'h03, a); mem[8] = 8'h03;
    bus_stop(); #(2*Q) chk_regs("R6 count reg written");
    rd_seq(2, 3, "R6");
    rd_seq(30, 3, "R5 read wrap");

    // R8 abort by STOP inside a data byte
    wr_head(8'd20, 8'd3, "R8");
    send_byte(8'h5A, a); mem[20] = 8'h5A;
    send_bits(8'hC3, 5);
    bus_stop(); #(2*Q) chk_regs("R8 stop abort keeps acked only");

    // R8 abort by repeated START, then read from the same index
    wr_head(8'd22, 8'd2, "R8 rs");
    send_bits(8'h77, 3);
    bus_start();
    send_byte(8'hD3, a); chk("R8 read after abort ack", a, 1);
    exp_v.push_back(mem[8]);  exp_r.push_back("R8 count after abort");
    exp_v.push_back(mem[22]); exp_r.push_back("R8 data after abort");
    recv_byte(1'b1); recv_byte(1'b0);
    bus_stop(); #(2*Q) chk_regs("R8 restart abort nothing stored");
    chk("R7 idle release", sda_oe, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule